// File: doc/BRIEF.md
# Tachometer Timer Register Front End

This block is the bus-facing register file of a fan tachometer timer. It takes single-cycle requests made of an address, a write flag, a size flag (byte or halfword) and write data, and returns a registered response one cycle later. The response carries read data and an error flag. Each register offset accepts exactly one access width. A request with the wrong width, an odd address or an unmapped offset gets an error response and has no side effect.

It holds the timer's configuration registers and presents them as control outputs to the capture datapath. That datapath is outside this block. It loads the two counter and two capture registers through hardware write ports and raises interrupt pending bits through a set vector. Software clears pending bits with a write-one-to-clear register that always reads as zero. Writes to the prescale or clock-control registers pulse a reload strobe so the channel clocks get recomputed. Every other accepted write pulses a re-evaluate strobe for the capture logic. Reset clears only the configuration and interrupt state. The counter and capture registers keep their contents.

Top module: `tach_regif`

## Requirements
- R1: The counter A (0x00), capture A (0x02), capture B (0x04), counter B (0x06), compare A (0x14) and compare B (0x16) offsets accept only halfword accesses (req_half_i=1). A byte access to any of them returns rsp_err_o=1.
- R2: The prescale (0x08), clock control (0x0A), mode (0x0C), pending (0x0E), clear (0x10), interrupt enable (0x12), compare config (0x18), input-select A (0x1A) and input-select B (0x1C) offsets accept only byte accesses. The following are rejected with rsp_err_o=1:
  - a halfword access to any of these offsets;
  - any odd address;
  - any offset above 0x1C.
- R3: A rejected write changes no register and pulses no strobe. A rejected read returns rsp_rdata_o=0.
- R4: An accepted halfword write stores all 16 data bits. An accepted byte write stores req_wdata_i[7:0]. A later read returns the stored value, with bits 15:8 reading as zero for byte registers. The configuration outputs show the stored values.
- R5: The clear register (0x10) is write-only. An accepted read of it returns zero with rsp_err_o=0.
- R6: An accepted write to the clear register clears each pending bit whose position is 1 in req_wdata_i[5:0] and leaves the other pending bits unchanged.
- R7: Pending bit k is set whenever hw_pnd_set_i[k] is 1. When that happens in the same cycle as a clear of bit k, the bit ends up set.
- R8: While rst_ni is low, the following are all zero and irq_o is low:
  - every register from prescale (0x08) through input-select B (0x1C);
  - the pending bits.
  Counter and capture registers keep their values across reset.
- R9: reload_o is high for exactly one cycle, in the response cycle of an accepted write to prescale (0x08) or clock control (0x0A).
- R10: reeval_o is high for exactly one cycle, in the response cycle of every other accepted write, the clear register included. Reads raise neither reload_o nor reeval_o.
- R11: irq_o is high exactly when some pending bit k (0..5) is set and bit k of the interrupt enable register is also set.
- R12: When hw_cc_we_i[n] is 1, counter/capture register n (0 counter A, 1 capture A, 2 capture B, 3 counter B) loads hw_cc_i[16n+15:16n]. This load takes priority over a bus write in the same cycle.
- R13: Every request cycle with req_valid_i=1 produces rsp_valid_o=1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_half_i | input | 1 | 1 = halfword, 0 = byte |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | DW | Write data, little-endian |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | DW | Read data |
| hw_cc_we_i | input | 4 | Hardware load of counter/capture registers |
| hw_cc_i | input | 4*DW | Hardware load values |
| hw_pnd_set_i | input | PND_W | Pending bit set vector |
| prescale_o | output | 8 | Prescale value |
| clk_ctrl_o | output | 8 | Clock control |
| mode_o | output | 8 | Mode control |
| irq_en_o | output | PND_W | Interrupt enables |
| cmp_a_o | output | DW | Compare A |
| cmp_b_o | output | DW | Compare B |
| cmp_cfg_o | output | 8 | Compare configuration |
| insel_a_o | output | 8 | Input select A |
| insel_b_o | output | 8 | Input select B |
| pending_o | output | PND_W | Pending bits |
| reload_o | output | 1 | Clock reload strobe |
| reeval_o | output | 1 | Capture re-evaluate strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked by the assertions on every cycle:
- each request gets a response in the next cycle;
- odd addresses are always rejected;
- reads never raise a strobe, and the two strobes never coincide;
- a hardware set always wins over a clear;
- a clear removes exactly the bits it names.

Other behaviours are shown only by the bench's scenarios:
- the complete width-legality map over every offset and both sizes;
- read-back of stored values;
- the absence of side effects from rejected writes;
- which registers survive a mid-run reset;
- the mapping from pending and enable bits to the interrupt.

// File: rtl/tach_regif_pkg.sv
package tach_regif_pkg;
  typedef enum logic [3:0] {
    RID_CNT_A    = 4'd0,
    RID_CAP_A    = 4'd1,
    RID_CAP_B    = 4'd2,
    RID_CNT_B    = 4'd3,
    RID_PRESCALE = 4'd4,
    RID_CLK_CTRL = 4'd5,
    RID_MODE     = 4'd6,
    RID_PEND     = 4'd7,
    RID_CLEAR    = 4'd8,
    RID_IRQ_EN   = 4'd9,
    RID_CMP_A    = 4'd10,
    RID_CMP_B    = 4'd11,
    RID_CMP_CFG  = 4'd12,
    RID_INSEL_A  = 4'd13,
    RID_INSEL_B  = 4'd14,
    RID_NONE     = 4'd15
  } reg_id_e;

  localparam int NREG = 16;
  localparam int NCC  = 4;

  function automatic logic reg_is_half(logic [3:0] id);
    return (id <= 4'(RID_CNT_B)) || (id == 4'(RID_CMP_A)) || (id == 4'(RID_CMP_B));
  endfunction
endpackage

// File: rtl/tach_access_check.sv
module tach_access_check
  import tach_regif_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr_i,
  input  logic          half_i,
  output logic          legal_o,
  output logic [3:0]    idx_o
);
  logic in_window;

  assign idx_o     = addr_i[4:1];
  assign in_window = (addr_i[AW-1:5] == '0) && (addr_i[4:1] != 4'(RID_NONE));
  // aligned and width must match the register's native size
  assign legal_o   = in_window && !addr_i[0] && (half_i == reg_is_half(addr_i[4:1]));
endmodule

// File: rtl/tach_pending_reg.sv
module tach_pending_reg #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] pnd_o
);
  logic [W-1:0] pnd_q, pnd_d;

  always_comb begin
    pnd_d = sw_we_i ? sw_wdata_i : pnd_q;
    if (clr_en_i) pnd_d = pnd_d & ~clr_mask_i;
    pnd_d = pnd_d | set_i; // hardware set wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pnd_q <= '0;
    else         pnd_q <= pnd_d;
  end

  assign pnd_o = pnd_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pnd_q & $past(set_i)) == $past(set_i)));

  a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !sw_we_i) |=> ((pnd_q & $past(clr_mask_i & ~set_i)) == '0));
endmodule

// File: rtl/tach_regif.sv
module tach_regif
  import tach_regif_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int PND_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_half_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DW-1:0]     rsp_rdata_o,
  input  logic [NCC-1:0]    hw_cc_we_i,
  input  logic [NCC*DW-1:0] hw_cc_i,
  input  logic [PND_W-1:0]  hw_pnd_set_i,
  output logic [7:0]        prescale_o,
  output logic [7:0]        clk_ctrl_o,
  output logic [7:0]        mode_o,
  output logic [PND_W-1:0]  irq_en_o,
  output logic [DW-1:0]     cmp_a_o,
  output logic [DW-1:0]     cmp_b_o,
  output logic [7:0]        cmp_cfg_o,
  output logic [7:0]        insel_a_o,
  output logic [7:0]        insel_b_o,
  output logic [PND_W-1:0]  pending_o,
  output logic              reload_o,
  output logic              reeval_o,
  output logic              irq_o
);
  localparam int BW = DW / 2;

  logic            legal;
  logic [3:0]      idx;
  logic            acc_wr, acc_rd;
  logic [NREG-1:0] wr_hit;
  logic [DW-1:0]   rd_arr [NREG];
  logic [PND_W-1:0] pnd;
  logic            is_clk_cfg;

  tach_access_check #(.AW(AW)) u_check (
    .addr_i  (req_addr_i),
    .half_i  (req_half_i),
    .legal_o (legal),
    .idx_o   (idx)
  );

  assign acc_wr     = req_valid_i && req_write_i && legal;
  assign acc_rd     = req_valid_i && !req_write_i && legal;
  assign wr_hit     = acc_wr ? (NREG'(1) << idx) : '0;
  assign is_clk_cfg = (idx == 4'(RID_PRESCALE)) || (idx == 4'(RID_CLK_CTRL));

  tach_pending_reg #(.W(PND_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (wr_hit[RID_PEND]),
    .sw_wdata_i (req_wdata_i[PND_W-1:0]),
    .clr_en_i   (wr_hit[RID_CLEAR]),
    .clr_mask_i (req_wdata_i[PND_W-1:0]),
    .set_i      (hw_pnd_set_i),
    .pnd_o      (pnd)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < NCC) begin : g_cc
      // counter/capture: retained across reset
      logic [DW-1:0] q;
      always_ff @(posedge clk_i) begin
        if (hw_cc_we_i[g])  q <= hw_cc_i[g*DW +: DW];
        else if (wr_hit[g]) q <= req_wdata_i;
      end
      assign rd_arr[g] = q;
    end else if (g == int'(RID_PEND)) begin : g_pend
      assign rd_arr[g] = DW'(pnd);
    end else if (g == int'(RID_CLEAR) || g == int'(RID_NONE)) begin : g_zero
      assign rd_arr[g] = '0;
    end else begin : g_cfg
      localparam int W = reg_is_half(4'(g)) ? DW : BW;
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= '0;
        else if (wr_hit[g]) q <= req_wdata_i[W-1:0];
      end
      assign rd_arr[g] = DW'(q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      reload_o    <= 1'b0;
      reeval_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && !legal;
      rsp_rdata_o <= acc_rd ? rd_arr[idx] : '0;
      reload_o    <= acc_wr && is_clk_cfg;
      reeval_o    <= acc_wr && !is_clk_cfg;
    end
  end

  assign prescale_o = rd_arr[RID_PRESCALE][7:0];
  assign clk_ctrl_o = rd_arr[RID_CLK_CTRL][7:0];
  assign mode_o     = rd_arr[RID_MODE][7:0];
  assign irq_en_o   = rd_arr[RID_IRQ_EN][PND_W-1:0];
  assign cmp_a_o    = rd_arr[RID_CMP_A];
  assign cmp_b_o    = rd_arr[RID_CMP_B];
  assign cmp_cfg_o  = rd_arr[RID_CMP_CFG][7:0];
  assign insel_a_o  = rd_arr[RID_INSEL_A][7:0];
  assign insel_b_o  = rd_arr[RID_INSEL_B][7:0];
  assign pending_o  = pnd;
  assign irq_o      = |(pnd & irq_en_o);

  a_r13_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_odd_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[0]) |=> rsp_err_o);

  a_r10_no_strobe_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> (!reload_o && !reeval_o));

  a_r9_strobe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reload_o && reeval_o));
endmodule

// File: tb/tach_regif_tb.sv
module tach_regif_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_half = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [3:0]    hw_cc_we = '0;
  logic [4*DW-1:0] hw_cc = '0;
  logic [PW-1:0] hw_set = '0;
  logic [7:0]    prescale, clk_ctrl, mode, cmp_cfg, insel_a, insel_b;
  logic [PW-1:0] irq_en, pending;
  logic [DW-1:0] cmp_a, cmp_b;
  logic          reload, reeval, irq;

  int n_checks = 0, n_fail = 0;
  logic r_valid, r_err, r_reload, r_reeval;
  logic [DW-1:0] r_data;

  tach_regif #(.AW(AW), .DW(DW), .PND_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_half_i(req_half),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .hw_cc_we_i(hw_cc_we), .hw_cc_i(hw_cc), .hw_pnd_set_i(hw_set),
    .prescale_o(prescale), .clk_ctrl_o(clk_ctrl), .mode_o(mode), .irq_en_o(irq_en),
    .cmp_a_o(cmp_a), .cmp_b_o(cmp_b), .cmp_cfg_o(cmp_cfg),
    .insel_a_o(insel_a), .insel_b_o(insel_b), .pending_o(pending),
    .reload_o(reload), .reeval_o(reeval), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_half(int a);
    return a == 0 || a == 2 || a == 4 || a == 6 || a == 20 || a == 22;
  endfunction

  function automatic bit exp_legal(int a, bit half);
    return (a % 2 == 0) && a <= 28 && (half == exp_half(a));
  endfunction

  // one request; results sampled 1 ns after the response edge
  task automatic acc(input bit wr, input int a, input bit half, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_half = half; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
    r_reload = reload; r_reeval = reeval;
  endtask

  function automatic logic [15:0] pat(int a, bit half);
    logic [15:0] v = 16'h5A01 + 16'(a) * 16'h0107;
    return half ? v : {8'h00, v[7:0]};
  endfunction

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset irq", irq, 0);
    check("R8 reset prescale", prescale, 0);
    check("R8 reset pending", pending, 0);
    check("R13 idle no rsp", rsp_valid, 0);
    @(negedge clk); rst_n = 1;

    // R1 R2 R3 R13: legality sweep over every offset and both sizes
    for (int a = 0; a < 34; a++) begin
      for (int h = 0; h < 2; h++) begin
        acc(0, a, h[0], 16'h0);
        check("R13 rsp valid", r_valid, 1);
        check(exp_half(a) ? "R1 width map" : "R2 width map", r_err, !exp_legal(a, h[0]));
        if (!exp_legal(a, h[0])) check("R3 rejected read data", r_data, 0);
        else if (a >= 8 && a != 0) check("R8 config zero after reset", r_data, 0);
        check("R10 read no strobe", {r_reload, r_reeval}, 0);
      end
    end

    // R4 R9 R10: write then read every storable register
    for (int a = 0; a <= 28; a += 2) begin
      if (a == 14 || a == 16) continue;
      acc(1, a, exp_half(a), pat(a, 1'b1));
      check("R9 reload strobe", r_reload, (a == 8 || a == 10));
      check("R10 reeval strobe", r_reeval, !(a == 8 || a == 10));
      acc(0, a, exp_half(a), 16'h0);
      check("R4 readback", r_data, pat(a, exp_half(a)));
    end
    check("R4 prescale_o", prescale, pat(8, 0));
    check("R4 cmp_a_o", cmp_a, pat(20, 1));
    check("R4 insel_b_o", insel_b, pat(28, 0));

    // R3: rejected writes leave state and strobes untouched
    acc(1, 0, 0, 16'hFFFF);
    check("R3 no strobe", {r_reload, r_reeval}, 0);
    acc(1, 8, 1, 16'hFFFF);
    acc(1, 9, 0, 16'hFFFF);
    acc(1, 30, 0, 16'hFFFF);
    acc(0, 0, 1, 0);  check("R3 counter kept", r_data, pat(0, 1));
    acc(0, 8, 0, 0);  check("R3 prescale kept", r_data, pat(8, 0));
    check("R3 prescale_o kept", prescale, pat(8, 0));

    // R5: clear register reads zero
    acc(0, 16, 0, 0);
    check("R5 clear err", r_err, 0);
    check("R5 clear reads zero", r_data, 0);

    // R6 R7 R11: pending handling
    acc(1, 18, 0, 16'h0000);
    @(negedge clk); hw_set = 6'h3F; @(negedge clk); hw_set = 0; #1;
    check("R7 hw set", pending, 6'h3F);
    check("R11 irq masked", irq, 0);
    acc(1, 16, 0, 16'h0005);
    check("R10 clear reeval", r_reeval, 1);
    check("R6 clear bits", pending, 6'h3A);
    acc(0, 14, 0, 0);
    check("R6 pending readback", r_data, 16'h003A);
    @(negedge clk); hw_set = 6'h02;
    acc(1, 16, 0, 16'h000A);
    hw_set = 0;
    check("R7 set wins", pending, 6'h32);
    acc(1, 18, 0, 16'h0008);
    check("R11 irq on disabled bit", irq, 0);
    acc(1, 18, 0, 16'h0010);
    check("R11 irq asserted", irq, 1);
    acc(1, 16, 0, 16'h0010);
    check("R11 irq after clear", irq, 0);

    // R12: hardware load of capture B, priority over bus write
    @(negedge clk); hw_cc_we = 4'b0100; hw_cc[2*DW +: DW] = 16'hBEEF;
    acc(1, 4, 1, 16'h1111);
    hw_cc_we = 0;
    acc(0, 4, 1, 0);
    check("R12 hw load wins", r_data, 16'hBEEF);

    // R8: mid-run reset keeps counters/captures, clears config
    @(negedge clk); hw_set = 6'h01;
    @(negedge clk); hw_set = 0;
    rst_n = 0; #1;
    check("R8 irq low in reset", irq, 0);
    check("R8 pending cleared", pending, 0);
    check("R8 cmp_b cleared", cmp_b, 0);
    @(negedge clk); rst_n = 1;
    acc(0, 4, 1, 0); check("R8 capture kept", r_data, 16'hBEEF);
    acc(0, 6, 1, 0); check("R8 counter kept", r_data, pat(6, 1));
    acc(0, 12, 0, 0); check("R8 mode cleared", r_data, 0);
    acc(0, 28, 0, 0); check("R8 insel_b cleared", r_data, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule